// File: doc/BRIEF.md
# Dual-lane double-edge serial frame transmitter

This block turns one parallel frame request into a serial burst on three wires: a forwarded clock and two data lanes. The request carries a frame type, between one and sixteen 16-bit data words, a precomputed CRC byte and a tag. The block adds a fixed start marker before these fields and a fixed end marker after them. It sends every field with the most significant bit first, and it holds all three wires high whenever it is not sending.

In the default mode, the clock line toggles once per system clock cycle. A new bit appears on every clock edge, both rising and falling. Four toggles with the data held high come before the frame, and four more come after it. When two-lane operation is selected, the data words and the CRC byte are split by bit parity across the two lanes, and both lanes carry the framing fields in full. A single-edge mode compatible with SPI receivers drops the surrounding toggles. In that mode each bit lasts two system cycles and changes only when the clock rises, so the receiver samples it on the falling edge.

Requests use a valid/ready handshake. All payload and mode inputs are captured in the cycle the request is accepted.

Top module: `fsx_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in flight, `tx_clk`, `tx_d0` and `tx_d1` are all 1 and `frm_ready` is 1.
- R2: In the default mode, the four cycles before the first start-marker bit and the four cycles after the last end-marker bit each toggle `tx_clk` while both data lanes stay 1. The first of these cycles drives `tx_clk` low.
- R3: In the default mode, `tx_clk` changes level in every cycle of a transfer, and one new bit (or lane pair) appears per cycle.
- R4: Fields go out in this order: start marker 4'b1001, frame type (4 bits), data words (word 0 first, taken from `frm_words[16*i +: 16]`), CRC (8 bits), tag (4 bits), end marker 4'b0110. Each field goes out MSB first, and single-lane mode uses `tx_d0`.
- R5: In two-lane mode, each data word and the CRC byte go out as bit pairs, highest pair first. `tx_d1` carries the odd bit (2k+1) and `tx_d0` carries the even bit (2k).
- R6: In two-lane mode, both lanes carry identical values during the start marker, type, tag and end marker. In single-lane mode, `tx_d1` stays 1 for the whole transfer.
- R7: In SPI-compatible mode there are no surrounding toggles. Each bit occupies two cycles, the first with `tx_clk` high and the second with `tx_clk` low, so data changes only together with a rise of `tx_clk`.
- R8: A request is taken only on a cycle where both `frm_valid` and `frm_ready` are 1. `frm_ready` is 0 from the cycle after acceptance through the last driven cycle of the transfer. While `frm_ready` is 0, `frm_valid` and every payload input are ignored.
- R9: `frm_last_word` holds the index of the final data word (the word count minus one). Exactly that many words plus one are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one serial bit period per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | Frame request present |
| frm_ready | output | 1 | Block idle and able to accept a request |
| frm_type | input | 4 | Frame type field |
| frm_last_word | input | WIDX_W (4) | Index of the last data word |
| frm_words | input | 16*MAX_WORDS (256) | Data words, word i at bits 16*i +: 16 |
| frm_crc | input | 8 | Precomputed CRC byte |
| frm_tag | input | 4 | Tag field |
| mode_two_lane | input | 1 | 1 = split data and CRC across two lanes |
| mode_spi | input | 1 | 1 = SPI-compatible single-edge mode |
| tx_clk | output | 1 | Forwarded serial clock |
| tx_d0 | output | 1 | Primary data lane |
| tx_d1 | output | 1 | Secondary data lane |

## Verification
The assertions assume that the payload and mode inputs matter only in the accept cycle, and that `frm_last_word` never points past the last stored word. The bench changes its request inputs only on falling clock edges. It changes payload and mode only when a new request is raised, or deliberately while a transfer is in flight to show those changes are ignored. It always drops `frm_valid` well before a transfer ends, so no unintended back-to-back acceptance occurs. The word index stays in range by construction of its width.

// File: rtl/fsx_pkg.sv
package fsx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_SOF, ST_TYPE, ST_DATA, ST_CRC, ST_TAG, ST_EOF, ST_POST
  } tx_state_e;

  // Index of the last cycle-slot within a field (count-down start value).
  function automatic logic [3:0] field_last(tx_state_e s, logic two);
    case (s)
      ST_DATA: return two ? 4'd7 : 4'd15;
      ST_CRC:  return two ? 4'd3 : 4'd7;
      default: return 4'd3;
    endcase
  endfunction

  // Field that follows s once s has been fully sent.
  function automatic tx_state_e next_field(tx_state_e s, logic spi, logic last_word);
    case (s)
      ST_PRE:  return ST_SOF;
      ST_SOF:  return ST_TYPE;
      ST_TYPE: return ST_DATA;
      ST_DATA: return last_word ? ST_CRC : ST_DATA;
      ST_CRC:  return ST_TAG;
      ST_TAG:  return ST_EOF;
      ST_EOF:  return spi ? ST_IDLE : ST_POST;
      default: return ST_IDLE;
    endcase
  endfunction

  // Lane values {d1,d0} for slot idx of value v.
  // split: field is divided by bit parity when two lanes are in use.
  function automatic logic [1:0] lane_pair(logic [15:0] v, logic [3:0] idx,
                                           logic two, logic split);
    logic [3:0] lo;
    logic [3:0] hi;
    lo = {idx[2:0], 1'b0};
    hi = {idx[2:0], 1'b1};
    if (two && split) return {v[hi], v[lo]};
    else if (two)     return {v[idx], v[idx]};
    else              return {1'b1, v[idx]};
  endfunction

endpackage

// File: rtl/fsx_seq.sv
module fsx_seq
  import fsx_pkg::*;
#(
  parameter int WIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              spi_i,
  input  logic              two_i,
  input  logic [WIDX_W-1:0] last_i,
  output tx_state_e         state_o,
  output logic [3:0]        cnt_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              spi_o,
  output logic              two_o,
  output logic              clk_o,
  output logic              ready_o
);

  tx_state_e         state_q;
  logic [3:0]        cnt_q;
  logic [WIDX_W-1:0] widx_q, last_q;
  logic              spi_q, two_q, clk_q;

  // Named internal events.
  logic      step;       // a bit slot completes this cycle
  logic      fld_end;    // final slot of the current field completes
  logic      word_last;  // current data word is the final one
  tx_state_e nxt;

  always_comb begin
    step      = spi_q ? ~clk_q : 1'b1;
    fld_end   = step && (cnt_q == 4'd0);
    word_last = (widx_q == last_q);
    nxt       = next_field(state_q, spi_q, word_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      widx_q  <= '0;
      last_q  <= '0;
      spi_q   <= 1'b0;
      two_q   <= 1'b0;
      clk_q   <= 1'b1;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= spi_i ? ST_SOF : ST_PRE;
        cnt_q   <= 4'd3;
        widx_q  <= '0;
        last_q  <= last_i;
        spi_q   <= spi_i;
        two_q   <= two_i;
        clk_q   <= spi_i;
      end
    end else begin
      clk_q <= (fld_end && nxt == ST_IDLE) ? 1'b1 : ~clk_q;
      if (fld_end) begin
        state_q <= nxt;
        cnt_q   <= field_last(nxt, two_q);
        if (state_q == ST_DATA && nxt == ST_DATA) widx_q <= widx_q + 1'b1;
      end else if (step) begin
        cnt_q <= cnt_q - 4'd1;
      end
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign widx_o  = widx_q;
  assign spi_o   = spi_q;
  assign two_o   = two_q;
  assign clk_o   = clk_q;
  assign ready_o = (state_q == ST_IDLE);

  // R8: acceptance makes the block busy on the next cycle.
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_i) |=> !ready_o);

  // R9: the word index never runs past the requested last word.
  p_word_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (widx_q <= last_q));

endmodule

// File: rtl/fsx_lane_mux.sv
module fsx_lane_mux
  import fsx_pkg::*;
#(
  parameter logic [3:0] SOF_PAT = 4'b1001,
  parameter logic [3:0] EOF_PAT = 4'b0110
) (
  input  tx_state_e   state_i,
  input  logic [3:0]  cnt_i,
  input  logic        two_i,
  input  logic [3:0]  type_i,
  input  logic [15:0] word_i,
  input  logic [7:0]  crc_i,
  input  logic [3:0]  tag_i,
  output logic        d0_o,
  output logic        d1_o
);

  logic [1:0] pair;

  always_comb begin
    case (state_i)
      ST_SOF:  pair = lane_pair({12'd0, SOF_PAT}, cnt_i, two_i, 1'b0);
      ST_TYPE: pair = lane_pair({12'd0, type_i},  cnt_i, two_i, 1'b0);
      ST_DATA: pair = lane_pair(word_i,            cnt_i, two_i, 1'b1);
      ST_CRC:  pair = lane_pair({8'd0, crc_i},    cnt_i, two_i, 1'b1);
      ST_TAG:  pair = lane_pair({12'd0, tag_i},   cnt_i, two_i, 1'b0);
      ST_EOF:  pair = lane_pair({12'd0, EOF_PAT}, cnt_i, two_i, 1'b0);
      default: pair = 2'b11;
    endcase
  end

  assign d1_o = pair[1];
  assign d0_o = pair[0];

endmodule

// File: rtl/fsx_tx.sv
module fsx_tx
  import fsx_pkg::*;
#(
  parameter int         MAX_WORDS = 16,
  parameter logic [3:0] SOF_PAT   = 4'b1001,
  parameter logic [3:0] EOF_PAT   = 4'b0110,
  localparam int        WIDX_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
  localparam int        PAY_W     = 16 * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [3:0]        frm_type,
  input  logic [WIDX_W-1:0] frm_last_word,
  input  logic [PAY_W-1:0]  frm_words,
  input  logic [7:0]        frm_crc,
  input  logic [3:0]        frm_tag,
  input  logic              mode_two_lane,
  input  logic              mode_spi,
  output logic              tx_clk,
  output logic              tx_d0,
  output logic              tx_d1
);

  logic              accept;
  logic              busy;
  tx_state_e         state;
  logic [3:0]        cnt;
  logic [WIDX_W-1:0] widx;
  logic              spi_q, two_q;

  logic [3:0]  type_q, tag_q;
  logic [7:0]  crc_q;
  logic [15:0] word_q [MAX_WORDS];

  assign accept = frm_valid && frm_ready;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      tag_q  <= '0;
      crc_q  <= '0;
    end else if (accept) begin
      type_q <= frm_type;
      tag_q  <= frm_tag;
      crc_q  <= frm_crc;
    end
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word_q[g] <= '0;
      else if (accept) word_q[g] <= frm_words[16*g +: 16];
    end
  end

  fsx_seq #(.WIDX_W(WIDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .spi_i   (mode_spi),
    .two_i   (mode_two_lane),
    .last_i  (frm_last_word),
    .state_o (state),
    .cnt_o   (cnt),
    .widx_o  (widx),
    .spi_o   (spi_q),
    .two_o   (two_q),
    .clk_o   (tx_clk),
    .ready_o (frm_ready)
  );

  fsx_lane_mux #(.SOF_PAT(SOF_PAT), .EOF_PAT(EOF_PAT)) u_mux (
    .state_i (state),
    .cnt_i   (cnt),
    .two_i   (two_q),
    .type_i  (type_q),
    .word_i  (word_q[widx]),
    .crc_i   (crc_q),
    .tag_i   (tag_q),
    .d0_o    (tx_d0),
    .d1_o    (tx_d1)
  );

  // R1: all lines idle high while no frame is in flight.
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_clk && tx_d0 && tx_d1 && frm_ready));

  // R2: surrounding toggles carry no data.
  p_pre_post_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_PRE, ST_POST}) |-> (tx_d0 && tx_d1));

  // R3: in the default mode the forwarded clock changes every cycle.
  p_ddr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !spi_q) |-> (tx_clk != $past(tx_clk)));

  // R6: framing fields are copied on both lanes in two-lane mode.
  p_lane_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (two_q && (state inside {ST_SOF, ST_TYPE, ST_TAG, ST_EOF})) |-> (tx_d0 == tx_d1));

  // R6: the second lane rests high in single-lane mode.
  p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !two_q) |-> tx_d1);

  // R7: single-edge mode changes data only with a rising clock.
  p_spi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && spi_q && $past(busy) && (tx_d0 != $past(tx_d0))) |-> (tx_clk && !$past(tx_clk)));

  // R7: single-edge mode never enters the surrounding toggle phases.
  p_spi_no_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_q |-> !(state inside {ST_PRE, ST_POST}));

endmodule

// File: tb/sim_fsx_tx.sv
`timescale 1ns/1ps
module sim_fsx_tx;

  localparam int         MAXW = 16;
  localparam logic [3:0] SOFV = 4'b1001;
  localparam logic [3:0] EOFV = 4'b0110;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frm_valid = 1'b0;
  logic            frm_ready;
  logic [3:0]      frm_type = '0;
  logic [3:0]      frm_last_word = '0;
  logic [16*MAXW-1:0] frm_words = '0;
  logic [7:0]      frm_crc = '0;
  logic [3:0]      frm_tag = '0;
  logic            mode_two_lane = 1'b0;
  logic            mode_spi = 1'b0;
  logic            tx_clk, tx_d0, tx_d1;

  always #2.5 clk = ~clk;

  fsx_tx #(.MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_type(frm_type), .frm_last_word(frm_last_word), .frm_words(frm_words),
    .frm_crc(frm_crc), .frm_tag(frm_tag), .mode_two_lane(mode_two_lane),
    .mode_spi(mode_spi), .tx_clk(tx_clk), .tx_d0(tx_d0), .tx_d1(tx_d1)
  );

  // Scoreboard: expected {ready,clk,d0,d1} per cycle plus requirement tag.
  logic [3:0] exp_q [$];
  string      req_q [$];
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       armed = 1'b0;

  task automatic put(input logic c, input logic a, input logic b, input string r);
    exp_q.push_back({1'b0, c, a, b});
    req_q.push_back(r);
  endtask

  // One bit slot: a toggle in the default mode, a high/low pair in SPI mode.
  task automatic slot(input logic spi, input logic a, input logic b,
                      input string r, inout logic c);
    if (spi) begin
      put(1'b1, a, b, r);
      put(1'b0, a, b, r);
    end else begin
      c = ~c;
      put(c, a, b, r);
    end
  endtask

  task automatic put_field(input logic two, input logic spi, input logic [15:0] v,
                           input int w, input bit split, input string r, inout logic c);
    if (two && split) begin
      for (int k = w/2 - 1; k >= 0; k--) slot(spi, v[2*k], v[2*k+1], r, c);
    end else begin
      for (int i = w - 1; i >= 0; i--) slot(spi, v[i], two ? v[i] : 1'b1, r, c);
    end
  endtask

  always @(negedge clk) begin
    if (armed && exp_q.size() > 0) begin
      logic [3:0] e;
      logic [3:0] act;
      string      r;
      e   = exp_q.pop_front();
      r   = req_q.pop_front();
      act = {frm_ready, tx_clk, tx_d0, tx_d1};
      n_cmp++;
      if (act !== e) begin
        n_bad++;
        $display("FAIL %s: {ready,clk,d0,d1} actual=%b expected=%b", r, act, e);
      end
    end
  end

  task automatic check_idle(input string r);
    n_cmp++;
    if ({frm_ready, tx_clk, tx_d0, tx_d1} !== 4'b1111) begin
      n_bad++;
      $display("FAIL %s: idle lines actual=%b expected=1111", r,
               {frm_ready, tx_clk, tx_d0, tx_d1});
    end
  endtask

  task automatic send(input logic two, input logic spi, input int nw,
                      input logic [3:0] typ, input logic [3:0] tg,
                      input logic [7:0] crc, input logic [15:0] seed, input bit poke);
    logic [15:0] wv [MAXW];
    logic        c;
    string       r;
    for (int i = 0; i < MAXW; i++) wv[i] = (seed ^ (16'(i) * 16'h3b1d)) + 16'(i);
    @(negedge clk);
    mode_two_lane = two;
    mode_spi      = spi;
    frm_type      = typ;
    frm_tag       = tg;
    frm_crc       = crc;
    frm_last_word = 4'(nw);
    for (int i = 0; i < MAXW; i++) frm_words[16*i +: 16] = wv[i];
    frm_valid = 1'b1;
    n_cmp++;
    if (frm_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R8: ready before request actual=%b expected=1", frm_ready);
    end
    // Build the expected waveform (R3/R4 single, R5/R6 dual, R7 spi, R9 count).
    c = 1'b1;
    r = spi ? "R7/R9" : (two ? "R5/R6/R9" : "R3/R4/R9");
    if (!spi) for (int i = 0; i < 4; i++) begin c = ~c; put(c, 1'b1, 1'b1, "R2"); end
    put_field(two, spi, {12'd0, SOFV}, 4, 1'b0, r, c);
    put_field(two, spi, {12'd0, typ},  4, 1'b0, r, c);
    for (int i = 0; i <= nw; i++) put_field(two, spi, wv[i], 16, 1'b1, r, c);
    put_field(two, spi, {8'd0, crc},   8, 1'b1, r, c);
    put_field(two, spi, {12'd0, tg},   4, 1'b0, r, c);
    put_field(two, spi, {12'd0, EOFV}, 4, 1'b0, r, c);
    if (!spi) for (int i = 0; i < 4; i++) begin c = ~c; put(c, 1'b1, 1'b1, "R2"); end
    @(posedge clk);
    armed = 1'b1;
    if (poke) begin
      // R8: request and payload changes while busy must have no effect.
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        frm_valid = 1'b1;
        frm_type = ~typ; frm_tag = ~tg; frm_crc = ~crc;
        mode_spi = ~spi; mode_two_lane = ~two;
        frm_words = ~frm_words;
      end
    end
    @(negedge clk);
    frm_valid = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    armed = 1'b0;
    check_idle("R1/R8");
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL R8: watchdog actual=hung expected=transfer complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");
    send(1'b0, 1'b0, 0,  4'h3, 4'hA, 8'h5C, 16'h1234, 1'b0);
    send(1'b1, 1'b0, 2,  4'hC, 4'h5, 8'hA7, 16'hBEEF, 1'b0);
    send(1'b0, 1'b1, 1,  4'h9, 4'h2, 8'h31, 16'h0F0F, 1'b0);
    send(1'b1, 1'b1, 15, 4'h6, 4'hE, 8'hD2, 16'h8001, 1'b0);
    send(1'b0, 1'b0, 15, 4'h1, 4'h7, 8'hFF, 16'h5555, 1'b1);
    send(1'b1, 1'b0, 0,  4'hF, 4'h0, 8'h00, 16'hC3A5, 1'b1);
    repeat (3) @(negedge clk);
    check_idle("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule